// File: doc/BRIEF.md
# PLL Divider Pair

This block holds the two programmable counters that sit in front of the phase detector of one synthesizer loop. The reference counter takes a stream of reference ticks, with an optional halving stage ahead of it, and divides it by R to produce phase-detector update ticks. The feedback counter takes a stream of oscillator-side ticks and divides it by N. For the two RF loop kinds a fixed divide-by-2 stage sits ahead of the N counter; for the IF loop kind it is absent. The loop kind is a parameter. It also sets the width of the N port and the smallest legal N.

A configuration is written in one cycle by pulsing the load strobe with R, N, a 2-bit gain code and the reference-halve flag. The gain code sets the smallest legal R. A configuration outside the legal window raises an illegal flag, and both counters then stay stopped so that no wrong-rate tick ever leaves the block. Any load restarts both counters. Ticks in and out are plain one-cycle strobes, not a stream: there is no valid/ready pair and no back-pressure. The block counts a tick in every cycle where the input is high, and an output pulse cannot be held back.

Top module: `pll_divider_pair`

## Requirements
- R1: After reset, upd_tick and fb_tick are low and cfg_illegal is high. This is because the reset configuration holds R = 0 and N = 0.
- R2: With a legal configuration and ref_half_in clear at load, upd_tick pulses once for every R counted reference ticks. The pulse comes in the cycle after the clock edge that sampled the R-th tick since the load.
- R3: With ref_half_in set at load, the reference path divides by 2R. The first upd_tick follows the 2R-th reference tick after the load.
- R4: The feedback path pulses fb_tick once per 2N oscillator ticks when KIND is RF1 or RF2, and once per N ticks when KIND is IF. The pulse comes in the cycle after the sampling edge.
- R5: The largest legal R is 8189. The smallest legal R depends on the gain code: 7 for code 0, 8 for code 1, 10 for code 2 and 14 for code 3. Any R outside this window sets cfg_illegal in the cycle after the load.
- R6: The N port is 18 bits wide for RF1, 17 bits for RF2 and 16 bits for IF. The smallest legal N is 992 for RF1, 240 for RF2 and 56 for IF. A smaller N sets cfg_illegal in the cycle after the load.
- R7: While cfg_illegal is high, both counters stay stopped. No upd_tick or fb_tick appears, whatever the tick inputs do.
- R8: A cfg_load clears both counters, both halving phases and any pending output pulse. Ticks presented in the load cycle are not counted, so the first pulse after a load needs a full new period.
- R9: Every output pulse lasts exactly one cycle. Two pulses on the same output are never in adjacent cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | One-cycle strobe that captures the configuration inputs |
| r_in | input | 13 | Reference divide ratio R |
| n_in | input | NW | Feedback divide ratio N (18, 17 or 16 bits by KIND) |
| gain_in | input | 2 | Phase-detector gain code; sets the smallest legal R |
| ref_half_in | input | 1 | Halve the reference ticks before the R counter |
| ref_tick | input | 1 | Reference tick strobe |
| vco_tick | input | 1 | Oscillator-side tick strobe |
| upd_tick | output | 1 | Phase-detector update pulse (reference path output) |
| fb_tick | output | 1 | Feedback pulse (feedback path output) |
| cfg_illegal | output | 1 | Captured configuration is outside its legal window |

## Verification
The hardest state to reach from the ports is a reload that arrives while a halving stage sits on its odd phase and the R counter is part-way through a period. A counter or phase that survives the reload only shows up as a pulse a few ticks early. The stimulus gets there by loading, feeding an odd number of dense ticks, and reloading the same ratio, with random ticks present during the load cycle itself. Every pulse cycle afterwards is compared with a reference count. The top of the R range with halving needs 16378 ticks per pulse, so one directed case runs a dense tick stream long enough to see that pulse land on the exact cycle.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

  typedef enum logic [1:0] {
    LOOP_RF1 = 2'd0,
    LOOP_RF2 = 2'd1,
    LOOP_IF  = 2'd2
  } loop_kind_e;

  localparam int R_W    = 13;
  localparam int GAIN_W = 2;
  localparam logic [R_W-1:0] R_CEIL = 13'd8189;

  typedef struct packed {
    logic [R_W-1:0]    r;
    logic [GAIN_W-1:0] gain;
    logic              halve;
  } ref_cfg_t;

  // width of the N field for each loop kind
  function automatic int n_width(loop_kind_e k);
    case (k)
      LOOP_RF1: return 18;
      LOOP_RF2: return 17;
      default:  return 16;
    endcase
  endfunction

  // smallest legal N for each loop kind
  function automatic int n_floor(loop_kind_e k);
    case (k)
      LOOP_RF1: return 992;
      LOOP_RF2: return 240;
      default:  return 56;
    endcase
  endfunction

  // RF loops carry a fixed divide-by-2 ahead of the N counter
  function automatic logic fb_prehalve(loop_kind_e k);
    return (k != LOOP_IF);
  endfunction

  // smallest legal R for a gain code
  function automatic logic [R_W-1:0] r_floor(logic [GAIN_W-1:0] g);
    case (g)
      2'd0:    return 13'd7;
      2'd1:    return 13'd8;
      2'd2:    return 13'd10;
      default: return 13'd14;
    endcase
  endfunction

endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check
  import pll_div_pkg::*;
#(
  parameter loop_kind_e KIND = LOOP_RF1,
  parameter int         NW   = 18
) (
  input  logic [R_W-1:0]    r_val,
  input  logic [NW-1:0]     n_val,
  input  logic [GAIN_W-1:0] gain,
  output logic              illegal
);

  localparam logic [NW-1:0] N_LO = NW'(n_floor(KIND));

  logic r_low;
  logic r_high;
  logic n_low;

  always_comb begin
    r_low   = (r_val < r_floor(gain));
    r_high  = (r_val > R_CEIL);
    n_low   = (n_val < N_LO);
    illegal = r_low | r_high | n_low;
  end

endmodule

// File: rtl/pll_tick_div.sv
module pll_tick_div #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          run,
  input  logic          prehalve,
  input  logic          tick_in,
  input  logic [CW-1:0] limit,
  output logic          tick_out
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic          phase;
  logic          last;
  logic          take;

  // a tick reaches the counter when the halving stage is bypassed or on its second phase
  assign take = ~prehalve | phase;
  assign last = (cnt == limit - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase    <= 1'b0;
      tick_out <= 1'b0;
    end else if (clear) begin
      cnt      <= '0;
      phase    <= 1'b0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= 1'b0;
      if (run && tick_in) begin
        phase <= prehalve & ~phase;
        if (take) begin
          if (last) begin
            cnt      <= '0;
            tick_out <= 1'b1;
          end else begin
            cnt <= cnt + ONE;
          end
        end
      end
    end
  end

endmodule

// File: rtl/pll_divider_pair.sv
module pll_divider_pair
  import pll_div_pkg::*;
#(
  parameter loop_kind_e KIND = LOOP_RF1,
  parameter int         NW   = n_width(KIND)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [R_W-1:0]    r_in,
  input  logic [NW-1:0]     n_in,
  input  logic [GAIN_W-1:0] gain_in,
  input  logic              ref_half_in,
  input  logic              ref_tick,
  input  logic              vco_tick,
  output logic              upd_tick,
  output logic              fb_tick,
  output logic              cfg_illegal
);

  localparam logic FB_HALVE = fb_prehalve(KIND);

  ref_cfg_t        ref_cfg;
  logic [NW-1:0]   n_cfg;
  logic            illegal;
  logic            counting;
  logic            fb_pre;

  // captured configuration; zero after reset, which is an illegal setting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cfg <= '0;
      n_cfg   <= '0;
    end else if (cfg_load) begin
      ref_cfg.r     <= r_in;
      ref_cfg.gain  <= gain_in;
      ref_cfg.halve <= ref_half_in;
      n_cfg         <= n_in;
    end
  end

  pll_cfg_check #(
    .KIND (KIND),
    .NW   (NW)
  ) u_check (
    .r_val   (ref_cfg.r),
    .n_val   (n_cfg),
    .gain    (ref_cfg.gain),
    .illegal (illegal)
  );

  assign counting    = ~illegal;
  assign cfg_illegal = illegal;

  pll_tick_div #(
    .CW (R_W)
  ) u_ref_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_load),
    .run      (counting),
    .prehalve (ref_cfg.halve),
    .tick_in  (ref_tick),
    .limit    (ref_cfg.r),
    .tick_out (upd_tick)
  );

  generate
    if (FB_HALVE) begin : g_rf_feedback
      assign fb_pre = 1'b1;
    end else begin : g_if_feedback
      assign fb_pre = 1'b0;
    end
  endgenerate

  pll_tick_div #(
    .CW (NW)
  ) u_fb_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (cfg_load),
    .run      (counting),
    .prehalve (fb_pre),
    .tick_in  (vco_tick),
    .limit    (n_cfg),
    .tick_out (fb_tick)
  );

endmodule

// File: rtl/pll_divider_pair_chk.sv
module pll_divider_pair_chk
  import pll_div_pkg::*;
#(
  parameter loop_kind_e KIND = LOOP_RF1,
  parameter int         NW   = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic [R_W-1:0]    r_in,
  input logic [NW-1:0]     n_in,
  input logic              ref_tick,
  input logic              vco_tick,
  input logic              upd_tick,
  input logic              fb_tick,
  input logic              cfg_illegal
);

  localparam logic [NW-1:0] N_LO = NW'(n_floor(KIND));

  assert_r_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && (r_in < 13'd7)) |=> cfg_illegal)
    else $error("R below every floor accepted");

  assert_r_ceil_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && (r_in > R_CEIL)) |=> cfg_illegal)
    else $error("R above ceiling accepted");

  assert_n_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && (n_in < N_LO)) |=> cfg_illegal)
    else $error("N below floor accepted");

  assert_silent_illegal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_illegal |-> (!upd_tick && !fb_tick))
    else $error("pulse while configuration illegal");

  assert_load_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!upd_tick && !fb_tick))
    else $error("pulse right after load");

  assert_upd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |=> !upd_tick)
    else $error("update pulse wider than one cycle");

  assert_fb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |=> !fb_tick)
    else $error("feedback pulse wider than one cycle");

  assert_upd_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |-> ($past(ref_tick) && !$past(cfg_load)))
    else $error("update pulse without a counted reference tick");

  assert_fb_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |-> ($past(vco_tick) && !$past(cfg_load)))
    else $error("feedback pulse without a counted oscillator tick");

endmodule

bind pll_divider_pair pll_divider_pair_chk #(
  .KIND (KIND),
  .NW   (NW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_load    (cfg_load),
  .r_in        (r_in),
  .n_in        (n_in),
  .ref_tick    (ref_tick),
  .vco_tick    (vco_tick),
  .upd_tick    (upd_tick),
  .fb_tick     (fb_tick),
  .cfg_illegal (cfg_illegal)
);

// File: tb/test_pll_divider_pair.sv
module test_pll_divider_pair;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_load;
  logic [12:0] r_in;
  logic [17:0] n_in;
  logic [1:0]  gain_in;
  logic        ref_half_in;
  logic        ref_tick;
  logic        vco_tick;
  logic        upd_o [3];
  logic        fb_o  [3];
  logic        ill_o [3];

  always #10 clk = ~clk;

  // instance 0: RF1, 1: RF2, 2: IF
  pll_divider_pair i_pll_divider_pair (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .r_in(r_in), .n_in(n_in[17:0]),
    .gain_in(gain_in), .ref_half_in(ref_half_in), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .upd_tick(upd_o[0]), .fb_tick(fb_o[0]), .cfg_illegal(ill_o[0]));

  pll_divider_pair #(.KIND(pll_div_pkg::LOOP_RF2)) i_pll_divider_pair_rf2 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .r_in(r_in), .n_in(n_in[16:0]),
    .gain_in(gain_in), .ref_half_in(ref_half_in), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .upd_tick(upd_o[1]), .fb_tick(fb_o[1]), .cfg_illegal(ill_o[1]));

  pll_divider_pair #(.KIND(pll_div_pkg::LOOP_IF)) i_pll_divider_pair_if (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .r_in(r_in), .n_in(n_in[15:0]),
    .gain_in(gain_in), .ref_half_in(ref_half_in), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .upd_tick(upd_o[2]), .fb_tick(fb_o[2]), .cfg_illegal(ill_o[2]));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int cur_r, cur_n, cur_g;
  bit cur_h;
  int ref_cnt, vco_cnt;
  bit e_upd [3];
  bit e_fb  [3];
  bit e_ill [3];
  int mm_upd [3];
  int mm_fb  [3];
  int mm_ill [3];
  bit prev_upd [3];
  bit prev_fb  [3];
  int back2back = 0;
  bit skip_cmp = 0;

  function automatic int floor_r(int g);
    case (g)
      0: return 7;
      1: return 8;
      2: return 10;
      default: return 14;
    endcase
  endfunction

  function automatic int floor_n(int k);
    case (k)
      0: return 992;
      1: return 240;
      default: return 56;
    endcase
  endfunction

  function automatic bit bad_cfg(int k, int r, int n, int g);
    return (r < floor_r(g)) || (r > 8189) || (n < floor_n(k));
  endfunction

  function automatic int fb_period(int k, int n);
    return (k == 2) ? n : 2 * n;
  endfunction

  function automatic bit rnd(int dens);
    return ($urandom_range(99) < dens);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_now();
    for (int k = 0; k < 3; k++) begin
      if (upd_o[k] !== e_upd[k]) mm_upd[k]++;
      if (fb_o[k] !== e_fb[k]) mm_fb[k]++;
      if (ill_o[k] !== e_ill[k]) mm_ill[k]++;
      if (upd_o[k] && prev_upd[k]) back2back++;
      if (fb_o[k] && prev_fb[k]) back2back++;
      prev_upd[k] = upd_o[k];
      prev_fb[k]  = fb_o[k];
    end
  endtask

  task automatic cycle(bit load, bit rt, bit vt, int r, int n, int g, bit h);
    if (!skip_cmp) compare_now();
    skip_cmp = 0;
    cfg_load = load;
    ref_tick = rt;
    vco_tick = vt;
    if (load) begin
      r_in = 13'(r); n_in = 18'(n); gain_in = 2'(g); ref_half_in = h;
      cur_r = r; cur_n = n; cur_g = g; cur_h = h;
      ref_cnt = 0; vco_cnt = 0;
      for (int k = 0; k < 3; k++) begin
        e_upd[k] = 0; e_fb[k] = 0;
        e_ill[k] = bad_cfg(k, r, n, g);
      end
    end else begin
      if (rt) ref_cnt++;
      if (vt) vco_cnt++;
      for (int k = 0; k < 3; k++) begin
        bit bad;
        int per;
        bad = bad_cfg(k, cur_r, cur_n, cur_g);
        per = cur_h ? 2 * cur_r : cur_r;
        e_upd[k] = !bad && rt && (ref_cnt % per == 0);
        e_fb[k]  = !bad && vt && (vco_cnt % fb_period(k, cur_n) == 0);
      end
    end
    @(negedge clk);
  endtask

  task automatic run_case(string tag, int r, int n, int g, bit h, int dr, int dv, int ncyc);
    cycle(1'b1, rnd(dr), rnd(dv), r, n, g, h);
    repeat (ncyc) cycle(1'b0, rnd(dr), rnd(dv), 0, 0, 0, 1'b0);
    compare_now();
    skip_cmp = 1;
    for (int k = 0; k < 3; k++) begin
      check(mm_upd[k] == 0, tag, $sformatf("upd_tick inst%0d r=%0d half=%0d mismatched cycles", k, r, h), mm_upd[k], 0);
      check(mm_fb[k] == 0, tag, $sformatf("fb_tick inst%0d n=%0d mismatched cycles", k, n), mm_fb[k], 0);
      check(mm_ill[k] == 0, tag, $sformatf("cfg_illegal inst%0d r=%0d n=%0d g=%0d mismatched cycles", k, r, n, g), mm_ill[k], 0);
      mm_upd[k] = 0; mm_fb[k] = 0; mm_ill[k] = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    rst_n = 1'b0; cfg_load = 1'b0; r_in = '0; n_in = '0; gain_in = '0;
    ref_half_in = 1'b0; ref_tick = 1'b0; vco_tick = 1'b0;
    for (int k = 0; k < 3; k++) begin
      e_upd[k] = 0; e_fb[k] = 0; e_ill[k] = 1; mm_upd[k] = 0; mm_fb[k] = 0; mm_ill[k] = 0;
      prev_upd[k] = 0; prev_fb[k] = 0;
    end
    repeat (3) @(negedge clk);
    ref_tick = 1'b1; vco_tick = 1'b1;
    @(negedge clk);
    // R1: reset state with ticks toggling
    for (int k = 0; k < 3; k++) begin
      check(upd_o[k] == 1'b0, "R1", $sformatf("upd_tick inst%0d in reset", k), upd_o[k], 0);
      check(fb_o[k] == 1'b0, "R1", $sformatf("fb_tick inst%0d in reset", k), fb_o[k], 0);
      check(ill_o[k] == 1'b1, "R1", $sformatf("cfg_illegal inst%0d in reset", k), ill_o[k], 1);
    end
    rst_n = 1'b1;
    ref_tick = 1'b0; vco_tick = 1'b0;
    @(negedge clk);
    // R1/R7: unconfigured block stays silent under ticks
    repeat (30) cycle(1'b0, 1'b1, 1'b1, 0, 0, 0, 1'b0);
    compare_now(); skip_cmp = 1;
    for (int k = 0; k < 3; k++) begin
      check(mm_upd[k] + mm_fb[k] + mm_ill[k] == 0, "R1", $sformatf("inst%0d silent before first load", k),
            mm_upd[k] + mm_fb[k] + mm_ill[k], 0);
      mm_upd[k] = 0; mm_fb[k] = 0; mm_ill[k] = 0;
    end

    // R2, R4: smallest R with dense ticks, N at the RF1 floor
    run_case("R2/R4", 7, 992, 0, 1'b0, 100, 100, 4100);
    // R3: top of R range with halving; RF1 idle by its N floor (R6/R7), others legal
    run_case("R3/R7", 8189, 240, 3, 1'b1, 100, 100, 16400);
    run_case("R3/R4", 14, 1000, 3, 1'b1, 60, 70, 3000);

    // R5: floors per gain code and the ceiling
    run_case("R5", 6, 1000, 0, 1'b0, 100, 100, 40);
    run_case("R5", 7, 1000, 0, 1'b0, 100, 100, 40);
    run_case("R5", 7, 1000, 1, 1'b0, 100, 100, 40);
    run_case("R5", 8, 1000, 1, 1'b0, 100, 100, 40);
    run_case("R5", 9, 1000, 2, 1'b0, 100, 100, 40);
    run_case("R5", 10, 1000, 2, 1'b0, 100, 100, 40);
    run_case("R5", 13, 1000, 3, 1'b0, 100, 100, 40);
    run_case("R5", 14, 1000, 3, 1'b0, 100, 100, 40);
    run_case("R5", 8190, 1000, 0, 1'b0, 100, 100, 40);
    run_case("R5", 8189, 1000, 0, 1'b0, 100, 100, 40);

    // R6: N floors per loop kind
    run_case("R6", 7, 991, 0, 1'b0, 100, 100, 200);
    run_case("R6", 7, 239, 0, 1'b0, 100, 100, 500);
    run_case("R6", 7, 55, 0, 1'b0, 100, 100, 100);
    run_case("R6/R4", 7, 56, 0, 1'b0, 100, 100, 300);

    // R8: reload mid-period, ticks present in the load cycle
    run_case("R8", 10, 60, 0, 1'b0, 100, 100, 37);
    run_case("R8", 10, 60, 0, 1'b0, 100, 100, 130);
    run_case("R8", 20, 1000, 0, 1'b1, 100, 100, 7);
    run_case("R8", 20, 1000, 0, 1'b1, 100, 100, 90);

    // constrained random configurations
    for (int i = 0; i < 8; i++) begin
      int rr, nn, gg, dr, dv;
      bit hh;
      rr = 6 + $urandom_range(40);
      nn = 50 + $urandom_range(1100);
      gg = $urandom_range(3);
      hh = 1'($urandom_range(1));
      dr = 30 + $urandom_range(70);
      dv = 30 + $urandom_range(70);
      run_case("R2/R3/R4/R5/R6/R7", rr, nn, gg, hh, dr, dv, 1500);
    end

    // R9: no output pulse longer than one cycle anywhere in the run
    check(back2back == 0, "R9", "adjacent-cycle pulses observed", back2back, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule